// File: doc/BRIEF.md
# Three-Wire Register Control Slave

This block is the software-facing configuration port of a larger device. A host drives a chip-select line (active low), a serial clock and a serial data line. Each transfer is a 16-bit word, most significant bit first: one direction flag (0 means write, 1 means read), a 7-bit register address and an 8-bit data byte. The block keeps a 128-entry, 8-bit register file and presents all of it on a flat configuration bus. Writes take effect only when chip select is released after exactly sixteen clocks. A write to address 0 returns every writable register to its default of zero.

Only a few addresses can be read back. Addresses 0 to 2 hold a fixed identity, and a small window of addresses holds status bytes that the surrounding logic supplies as inputs. Two read-back methods exist, and one bit of a control register picks between them. With that bit clear, a read command returns the addressed byte. With it set, every write also returns a status byte chosen by a 3-bit selector in the same control register. The returned byte is shifted out during the data half of the word. The output-enable line lets a pad drive the data-out pin only while chip select is low.

The serial lines are oversampled in the system clock domain through synchronisers. The serial clock must therefore run well below the system clock.

Top module: `twreg_slave`

## Requirements
- R1: The data line is sampled on rising serial-clock edges, MSB first. The word is {dir, addr[6:0], data[7:0]}. With dir=0 and address A writable, register A becomes the data byte, seen at cfgFlat[8*A +: 8].
- R2: A write does not alter cfgFlat before chip select rises. It takes effect within a few system clocks after the rise.
- R3: A transfer with any count of rising serial-clock edges other than 16 is discarded, with no write and no reset.
- R4: sdoOe is low while chip select is high and high while it is low, each after the two-stage synchroniser delay.
- R5: With the continuous bit clear and dir=1, the byte at the addressed location appears on sdoData, MSB first. It changes after falling serial-clock edges 8 to 15, so the host samples it on rising edges 9 to 16. Nothing is written.
- R6: The readable set for direct reads is as follows. Address 0, 1 and 2 give DEV_ID[7:0], [15:8] and [23:16]. Address 12+k (k = 0..3) gives statusIn[8k +: 8]. Every other address returns 0x00.
- R7: The control register sits at address 8. Bit 3 is the continuous bit and bits 2:0 are the selector. With the continuous bit set and dir=0, the write is performed and the data phase returns a selected byte. Selector values 0 to 2 give the identity bytes, 3 to 6 give status byte (value-3), and 7 gives 0x00. The selector and bit used are those in force before the transfer.
- R8: A read with the continuous bit set returns 0x00 and writes nothing. A write with the continuous bit clear returns 0x00.
- R9: A 16-clock write to address 0 clears every writable register, including the control register, whatever data byte is sent.
- R10: Writes to addresses 1, 2 and 12 to 15 are ignored. Those cfgFlat bytes stay zero.
- R11: After reset, cfgFlat is all zero, sdoOe is 0 and sdoData is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous-assert, active-low reset |
| csN | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| statusIn | input | 32 | Four status bytes, byte k at bits 8k+7:8k |
| sdoData | output | 1 | Serial read-back data |
| sdoOe | output | 1 | Output enable for the data-out pad |
| cfgFlat | output | 1024 | Register file, entry A at bits 8A+7:8A |

## Verification
The bench builds the block with its default parameters: a 7-bit address, 8-bit data, three identity bytes, four status bytes at 12 to 15 and the control register at 8. At that size every address fits in a sweep. Each of the 128 locations is written and compared against a bench-side model over the whole configuration bus. Each location is then read directly, and every selector value is exercised through dummy writes. The small word lets the bench cover short, long and mode-crossed transfers and the soft reset in the same run.

// File: rtl/twreg_pkg.sv
package twreg_pkg;

  // Strobes from the serial control toward the datapath.
  typedef struct packed {
    logic start;    // chip select fell: clear shift state
    logic shiftIn;  // rising serial clock: capture one input bit
    logic loadTx;   // header complete: load the return byte
    logic shiftTx;  // falling serial clock in data phase: present next bit
    logic commit;   // chip select rose after a full word
  } twStrobe_t;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RESET_VAL}};
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/twreg_ctrl.sv
module twreg_ctrl
  import twreg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csN,
  input  logic      sclk,
  input  logic      sdi,
  output logic      sdiS,
  output logic      sdoOe,
  output twStrobe_t stb
);

  localparam int HDR_BITS  = 1 + ADDR_W;
  localparam int WORD_BITS = HDR_BITS + DATA_W;
  localparam int CNT_W     = $clog2(WORD_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_HDR_LAST = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_HDR      = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] CNT_FULL     = CNT_W'(WORD_BITS);
  localparam logic [CNT_W-1:0] CNT_SAT      = CNT_W'(WORD_BITS + 1);

  logic [2:0] rawIn;
  logic [2:0] syncOut;
  logic csS, sclkS;
  logic csD, sclkD;
  logic [CNT_W-1:0] bitCnt;

  assign rawIn = {sdi, sclk, csN};

  for (genvar g = 0; g < 3; g++) begin : g_sync
    tw_sync #(
      .STAGES   (SYNC_STAGES),
      .RESET_VAL(g == 0 ? 1'b1 : 1'b0)
    ) u_sync (
      .clk (clk),
      .rstN(rstN),
      .d   (rawIn[g]),
      .q   (syncOut[g])
    );
  end

  assign csS   = syncOut[0];
  assign sclkS = syncOut[1];
  assign sdiS  = syncOut[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csD   <= 1'b1;
      sclkD <= 1'b0;
    end else begin
      csD   <= csS;
      sclkD <= sclkS;
    end
  end

  logic csFall, csRise, sclkRise, sclkFall;
  assign csFall   = csD & ~csS;
  assign csRise   = ~csD & csS;
  assign sclkRise = ~sclkD & sclkS & ~csS;
  assign sclkFall = sclkD & ~sclkS & ~csS;

  // Counts rising serial-clock edges, saturating one past a full word.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              bitCnt <= '0;
    else if (csFall)                        bitCnt <= '0;
    else if (sclkRise && bitCnt != CNT_SAT) bitCnt <= bitCnt + 1'b1;
  end

  always_comb begin
    stb.start   = csFall;
    stb.shiftIn = sclkRise;
    stb.loadTx  = sclkRise && (bitCnt == CNT_HDR_LAST);
    stb.shiftTx = sclkFall && (bitCnt >= CNT_HDR) && (bitCnt < CNT_FULL);
    stb.commit  = csRise && (bitCnt == CNT_FULL);
  end

  assign sdoOe = ~csS;

endmodule

// File: rtl/twreg_dp.sv
module twreg_dp
  import twreg_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int ID_BYTES    = 3,
  parameter int NUM_STATUS  = 4,
  parameter int STATUS_BASE = 12,
  parameter int CTRL_ADDR   = 8,
  parameter int CONT_BIT    = 3,
  parameter int MUX_W       = 3,
  parameter logic [ID_BYTES*DATA_W-1:0] DEV_ID = 24'h02_3C_A5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  twStrobe_t                    stb,
  input  logic                         sdiS,
  input  logic [NUM_STATUS*DATA_W-1:0] statusIn,
  output logic [(1<<ADDR_W)*DATA_W-1:0] cfgFlat,
  output logic                         sdoData,
  output logic [ADDR_W+DATA_W:0]       rxWord
);

  localparam int DEPTH     = 1 << ADDR_W;
  localparam int WORD_BITS = 1 + ADDR_W + DATA_W;
  localparam int SRC_N     = ID_BYTES + NUM_STATUS;

  function automatic bit isWritable(int a);
    return !(a < ID_BYTES) && !(a >= STATUS_BASE && a < STATUS_BASE + NUM_STATUS);
  endfunction

  function automatic int srcAddr(int k);
    return (k < ID_BYTES) ? k : STATUS_BASE + k - ID_BYTES;
  endfunction

  // Receive shifter
  logic [WORD_BITS-1:0] rxShift;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rxShift <= '0;
    else if (stb.start)   rxShift <= '0;
    else if (stb.shiftIn) rxShift <= {rxShift[WORD_BITS-2:0], sdiS};
  end
  assign rxWord = rxShift;

  // Header as seen on the rising edge that completes it
  logic [ADDR_W:0]   hdr;
  logic              hdrRead;
  logic [ADDR_W-1:0] hdrAddr;
  assign hdr     = {rxShift[ADDR_W-1:0], sdiS};
  assign hdrRead = hdr[ADDR_W];
  assign hdrAddr = hdr[ADDR_W-1:0];

  // Readable sources: identity bytes then status bytes
  logic [DATA_W-1:0] srcBytes [SRC_N];
  for (genvar k = 0; k < SRC_N; k++) begin : g_src
    if (k < ID_BYTES) begin : g_id
      assign srcBytes[k] = DEV_ID[k*DATA_W +: DATA_W];
    end else begin : g_stat
      assign srcBytes[k] = statusIn[(k-ID_BYTES)*DATA_W +: DATA_W];
    end
  end

  logic [DATA_W-1:0] ctrlByte;
  logic              contMode;
  logic [MUX_W-1:0]  muxSel;
  assign ctrlByte = cfgFlat[CTRL_ADDR*DATA_W +: DATA_W];
  assign contMode = ctrlByte[CONT_BIT];
  assign muxSel   = ctrlByte[MUX_W-1:0];

  logic [DATA_W-1:0] dirVal, muxVal, txNext;
  always_comb begin
    dirVal = '0;
    muxVal = '0;
    for (int k = 0; k < SRC_N; k++) begin
      if (int'(hdrAddr) == srcAddr(k)) dirVal = srcBytes[k];
      if (int'(muxSel) == k)           muxVal = srcBytes[k];
    end
    if (!contMode && hdrRead)      txNext = dirVal;
    else if (contMode && !hdrRead) txNext = muxVal;
    else                           txNext = '0;
  end

  // Transmit shifter
  logic [DATA_W-1:0] txReg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg   <= '0;
      sdoData <= 1'b0;
    end else if (stb.start) begin
      txReg   <= '0;
      sdoData <= 1'b0;
    end else if (stb.loadTx) begin
      txReg   <= txNext;
    end else if (stb.shiftTx) begin
      sdoData <= txReg[DATA_W-1];
      txReg   <= {txReg[DATA_W-2:0], 1'b0};
    end
  end

  // Register file with commit on chip-select release
  logic              commitWr, softRst;
  logic [ADDR_W-1:0] wAddr;
  logic [DATA_W-1:0] wData;
  assign commitWr = stb.commit && !rxShift[WORD_BITS-1];
  assign wAddr    = rxShift[DATA_W +: ADDR_W];
  assign wData    = rxShift[DATA_W-1:0];
  assign softRst  = commitWr && (wAddr == '0);

  for (genvar i = 0; i < DEPTH; i++) begin : g_reg
    if (isWritable(i)) begin : g_rw
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                    q <= '0;
        else if (softRst)                             q <= '0;
        else if (commitWr && wAddr == ADDR_W'(i))     q <= wData;
      end
      assign cfgFlat[i*DATA_W +: DATA_W] = q;
    end else begin : g_ro
      assign cfgFlat[i*DATA_W +: DATA_W] = '0;
    end
  end

endmodule

// File: rtl/twreg_slave.sv
module twreg_slave
  import twreg_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ID_BYTES    = 3,
  parameter int NUM_STATUS  = 4,
  parameter int STATUS_BASE = 12,
  parameter int CTRL_ADDR   = 8,
  parameter int CONT_BIT    = 3,
  parameter int MUX_W       = 3,
  parameter logic [ID_BYTES*DATA_W-1:0] DEV_ID = 24'h02_3C_A5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          csN,
  input  logic                          sclk,
  input  logic                          sdi,
  input  logic [NUM_STATUS*DATA_W-1:0]  statusIn,
  output logic                          sdoData,
  output logic                          sdoOe,
  output logic [(1<<ADDR_W)*DATA_W-1:0] cfgFlat
);

  twStrobe_t              stb;
  logic                   sdiS;
  logic [ADDR_W+DATA_W:0] rxWord;

  twreg_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W)
  ) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .csN  (csN),
    .sclk (sclk),
    .sdi  (sdi),
    .sdiS (sdiS),
    .sdoOe(sdoOe),
    .stb  (stb)
  );

  twreg_dp #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .ID_BYTES   (ID_BYTES),
    .NUM_STATUS (NUM_STATUS),
    .STATUS_BASE(STATUS_BASE),
    .CTRL_ADDR  (CTRL_ADDR),
    .CONT_BIT   (CONT_BIT),
    .MUX_W      (MUX_W),
    .DEV_ID     (DEV_ID)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .sdiS    (sdiS),
    .statusIn(statusIn),
    .cfgFlat (cfgFlat),
    .sdoData (sdoData),
    .rxWord  (rxWord)
  );

endmodule

// File: rtl/twreg_chk.sv
module twreg_chk
  import twreg_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int CTRL_ADDR = 8
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          csN,
  input logic                          sdoOe,
  input logic                          sdoData,
  input logic [(1<<ADDR_W)*DATA_W-1:0] cfgFlat,
  input twStrobe_t                     stb,
  input logic [ADDR_W+DATA_W:0]        rxWord
);

  localparam int WB = 1 + ADDR_W + DATA_W;

  // R4: chip select high two cycles back keeps the pad released
  p_pad_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(csN, 2) |-> !sdoOe);

  // R2: configuration only moves on a commit strobe
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commit |=> $stable(cfgFlat));

  // R1: a committed write to the control register lands there
  p_wrdata_r1: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && !rxWord[WB-1] && rxWord[DATA_W +: ADDR_W] == ADDR_W'(CTRL_ADDR))
    |=> cfgFlat[CTRL_ADDR*DATA_W +: DATA_W] == $past(rxWord[DATA_W-1:0]));

  // R9: write to address zero clears the whole file
  p_softrst_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && !rxWord[WB-1] && rxWord[DATA_W +: ADDR_W] == '0)
    |=> cfgFlat == '0);

  // R5: a read command never changes the configuration
  p_read_nowrite_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && rxWord[WB-1]) |=> $stable(cfgFlat));

  // R5: returned bit only moves on a shift or a new transfer
  p_sdo_steady_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.shiftTx && !stb.start) |=> $stable(sdoData));

endmodule

bind twreg_slave twreg_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .csN    (csN),
  .sdoOe  (sdoOe),
  .sdoData(sdoData),
  .cfgFlat(cfgFlat),
  .stb    (stb),
  .rxWord (rxWord)
);

// File: tb/twreg_slave_tb.sv
module twreg_slave_tb;

  localparam int HALF  = 8;
  localparam int DEPTH = 128;

  logic clk = 1'b0;
  logic rstN, csN, sclk, sdi;
  logic [31:0]   statusIn;
  logic          sdoData, sdoOe;
  logic [1023:0] cfgFlat;

  always #10 clk = ~clk;

  twreg_slave u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .statusIn(statusIn), .sdoData(sdoData), .sdoOe(sdoOe), .cfgFlat(cfgFlat)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  logic [7:0] model [DEPTH];
  localparam logic [23:0] ID = 24'h02_3C_A5;

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit writable(int a);
    return !(a < 3) && !(a >= 12 && a < 16);
  endfunction

  function automatic logic [7:0] srcByte(int k);
    if (k < 3) return ID[k*8 +: 8];
    return statusIn[(k-3)*8 +: 8];
  endfunction

  function automatic logic [7:0] expRet(logic w, int a);
    logic cont = model[8][3];
    int m = int'(model[8][2:0]);
    if (!cont && w) begin
      if (a < 3) return srcByte(a);
      if (a >= 12 && a < 16) return srcByte(a - 12 + 3);
      return 8'h00;
    end
    if (cont && !w) return (m < 7) ? srcByte(m) : 8'h00;
    return 8'h00;
  endfunction

  function automatic logic [1023:0] expFlat();
    logic [1023:0] f = '0;
    for (int i = 0; i < DEPTH; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  task automatic chkBit(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic chkByte(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic chkCfg(input string req);
    logic [1023:0] e = expFlat();
    vectors++;
    if (cfgFlat !== e) begin
      miscompares++;
      $display("FAIL %s: cfg got %h expected %h", req, cfgFlat, e);
    end
  endtask

  task automatic xfer(input logic w, input logic [6:0] a, input logic [7:0] d,
                      input int nclk, input string req);
    logic [15:0] word = {w, a, d};
    logic [7:0]  rx = '0;
    logic [7:0]  er = expRet(w, int'(a));
    csN = 1'b0;
    waitc(HALF);
    chkBit("R4", sdoOe, 1'b1);
    for (int i = 0; i < nclk; i++) begin
      sdi = (i < 16) ? word[15-i] : 1'b0;
      waitc(HALF);
      if (i >= 8 && i < 16) rx[15-i] = sdoData;
      sclk = 1'b1;
      waitc(HALF);
      sclk = 1'b0;
    end
    waitc(HALF);
    chkCfg("R2");  // nothing committed while chip select is low
    csN = 1'b1;
    waitc(HALF);
    chkBit("R4", sdoOe, 1'b0);
    if (nclk == 16) begin
      chkByte(req, rx, er);
      if (!w) begin
        if (a == 0) begin
          for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
        end else if (writable(int'(a))) begin
          model[a] = d;
        end
      end
    end
    chkCfg(req);
  endtask

  initial begin
    rstN = 1'b0; csN = 1'b1; sclk = 1'b0; sdi = 1'b0;
    statusIn = 32'hD4_6B_90_2E;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    waitc(5);
    rstN = 1'b1;
    waitc(4);
    // R11: reset state
    chkCfg("R11");
    chkBit("R11", sdoOe, 1'b0);
    chkBit("R11", sdoData, 1'b0);

    // R1 / R10 / R8: write sweep, continuous bit stays clear
    for (int a = 1; a < DEPTH; a++) begin
      logic [7:0] v = 8'((a * 37 + 11) & 255);
      if (a == 8) v = 8'h05;
      xfer(1'b0, 7'(a), v, 16, writable(a) ? "R1" : "R10");
    end

    // R5 / R6: direct read of every address
    for (int a = 0; a < DEPTH; a++)
      xfer(1'b1, 7'(a), 8'h5A, 16, (a < 3 || (a >= 12 && a < 16)) ? "R6" : "R5");

    // R7: every selector value, returned during dummy writes
    for (int m = 0; m < 8; m++) begin
      xfer(1'b0, 7'd8, 8'(8 | m), 16, "R7");
      xfer(1'b0, 7'h20, 8'(m * 3 + 1), 16, "R7");
    end

    // R8: reads with continuous bit set return zero and write nothing
    xfer(1'b1, 7'h01, 8'hFF, 16, "R8");
    xfer(1'b1, 7'h30, 8'hC3, 16, "R8");

    // R3: wrong clock counts are discarded
    xfer(1'b0, 7'h40, 8'hAA, 15, "R3");
    xfer(1'b0, 7'h40, 8'hBB, 17, "R3");
    xfer(1'b0, 7'h00, 8'h00, 8,  "R3");
    xfer(1'b0, 7'h00, 8'h00, 24, "R3");
    xfer(1'b0, 7'h40, 8'hCC, 16, "R2");

    // R9: soft reset, then direct reads work again
    xfer(1'b0, 7'h00, 8'hFF, 16, "R9");
    xfer(1'b1, 7'h02, 8'h00, 16, "R9");
    xfer(1'b1, 7'h0F, 8'h00, 16, "R9");
    xfer(1'b0, 7'h41, 8'h77, 16, "R9");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule